// File: doc/BRIEF.md
# Dual-Mode FIFO With Programmable Flags

A single-clock, parameterized FIFO that is locked into one of two read timing modes while reset is held. In standard mode a word leaves the FIFO only when the consumer asserts read enable. The two status outputs then mean "holds data" (high) and "has room" (high). In fall-through mode the oldest word is placed on the data output without any request. The read status output then goes low when the output word is valid, and the write status output goes high when no space is left. In this mode the output register counts as one extra storage slot, so the capacity is DEPTH+1 words.

Both modes drive three active-low level flags: half-full, near-empty and near-full. Their thresholds come from an empty offset n and a full offset m, which a neighbouring offset register block supplies. The thresholds move up by one word in fall-through mode, because of the extra output slot. An internal occupancy counter drives every flag comparison. All flags are registered and are updated at the same clock edge that applies the read or write.

Top module: `dualmode_fifo`

## Requirements
- R1: `mode_sel` is sampled only while `rst_n` is low: 0 selects standard mode and 1 selects fall-through mode. While in reset, `rd_data` clears to 0. After the first reset edge the flags show an empty FIFO in the chosen mode: standard gives `rd_stat`=0 and `wr_stat`=1, fall-through gives `rd_stat`=1 and `wr_stat`=0. In both modes `half_n`=1, `near_empty_n`=0 and `near_full_n`=1. Changing `mode_sel` outside reset has no effect.
- R2: Standard mode holds DEPTH words. `rd_stat` is 1 exactly when at least one word is stored. `wr_stat` drops to 0 after DEPTH writes with no reads.
- R3: Fall-through mode holds DEPTH+1 words. `rd_stat` is 0 exactly when a valid word is on `rd_data`. `wr_stat` rises to 1 after DEPTH+1 writes with no reads.
- R4: In fall-through mode, the first word written into an empty FIFO appears on `rd_data` at the edge that accepts the write, with no read enable. It stays there until a read enable consumes it. In standard mode `rd_data` changes only at an edge that accepts a read.
- R5: In standard mode `near_empty_n` is 1 when the count is n+1 or more, and 0 when the count is n or less.
- R6: In fall-through mode `near_empty_n` is 1 when the count is n+2 or more, and 0 when the count is n+1 or less.
- R7: `half_n` is 0 when the count is DEPTH/2+1 or more in standard mode, or DEPTH/2+2 or more in fall-through mode. Otherwise it is 1.
- R8: `near_full_n` is 0 when the count is DEPTH-m or more in standard mode, or DEPTH+1-m or more in fall-through mode. Otherwise it is 1.
- R9: A read enable while the FIFO is empty changes neither the flags nor `rd_data`. A write while the FIFO is full stores nothing.
- R10: When the FIFO is full, one accepted read clears the full indication at that edge.
- R11: When read and write are requested in the same cycle, the flags at the start of that cycle decide what happens. At full, only the read is done. At empty, only the write is done.
- R12: Words leave in the order they were written, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset; mode is sampled while low |
| mode_sel | input | 1 | Read timing mode choice: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered output word |
| empty_ofs | input | log2(DEPTH) | Empty offset n |
| full_ofs | input | log2(DEPTH) | Full offset m |
| rd_stat | output | 1 | Standard: 1 = data present; fall-through: 0 = output word valid |
| wr_stat | output | 1 | Standard: 0 = full; fall-through: 1 = full |
| half_n | output | 1 | Low when more than half full |
| near_empty_n | output | 1 | Low when at or below the empty threshold |
| near_full_n | output | 1 | Low when at or above the full threshold |

## Verification
Each flag and `rd_data` is computed from the state that follows the current cycle's operation and is loaded at that same rising edge, so every result is due exactly one edge after the request is presented. This includes the fall-through head word and the reset flag values. The bench applies each request at a falling edge and samples all outputs at the next falling edge. It compares them there against a queue model that counts stored words from the requirements. In fall-through mode it checks the head word only while the model count is non-zero.

// File: rtl/dmfifo_pkg.sv
package dmfifo_pkg;

   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FALL = 1'b1
   } rd_mode_e;

   typedef struct packed {
      logic rd_stat;
      logic wr_stat;
      logic half_n;
      logic near_empty_n;
      logic near_full_n;
   } flag_set_t;

endpackage

// File: rtl/dmfifo_store.sv
module dmfifo_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] head_word
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("dmfifo_store: DEPTH must be a power of two and at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr;
   logic [AW-1:0]     rptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (push) wptr <= wptr + AW'(1);
         if (pop)  rptr <= rptr + AW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= wr_data;
   end

   assign head_word = mem[rptr];

endmodule

// File: rtl/dmfifo_ctrl.sv
module dmfifo_ctrl
   import dmfifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  rd_mode_e                mode,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [DATA_W-1:0]       head_word,
   output logic                    push,
   output logic                    pop,
   output logic [DATA_W-1:0]       rd_data,
   output logic [$clog2(DEPTH):0]  tot_nxt
);
   localparam int CW = $clog2(DEPTH) + 1;

   logic [CW-1:0] mem_cnt, mem_cnt_nxt, tot;
   logic          out_vld, out_vld_nxt;
   logic          can_rd, can_wr, rd_ok, wr_ok;
   logic          slot_free, load_mem, bypass;

   always_comb begin
      tot = mem_cnt + CW'(out_vld);
      if (mode == MODE_FALL) begin
         can_rd = out_vld;
         can_wr = (tot != CW'(DEPTH + 1));
      end else begin
         can_rd = (mem_cnt != '0);
         can_wr = (mem_cnt != CW'(DEPTH));
      end
      rd_ok = rd_en & can_rd;
      wr_ok = wr_en & can_wr;

      if (mode == MODE_FALL) begin
         slot_free   = ~out_vld | rd_ok;
         load_mem    = slot_free & (mem_cnt != '0);
         bypass      = slot_free & (mem_cnt == '0) & wr_ok;
         pop         = load_mem;
         push        = wr_ok & ~bypass;
         out_vld_nxt = slot_free ? (load_mem | bypass) : 1'b1;
      end else begin
         slot_free   = 1'b0;
         load_mem    = rd_ok;
         bypass      = 1'b0;
         pop         = rd_ok;
         push        = wr_ok;
         out_vld_nxt = 1'b0;
      end

      mem_cnt_nxt = mem_cnt + CW'(push) - CW'(pop);
      tot_nxt     = mem_cnt_nxt + CW'(out_vld_nxt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_cnt <= '0;
         out_vld <= 1'b0;
         rd_data <= '0;
      end else begin
         mem_cnt <= mem_cnt_nxt;
         out_vld <= out_vld_nxt;
         if (load_mem)    rd_data <= head_word;
         else if (bypass) rd_data <= wr_data;
      end
   end

endmodule

// File: rtl/dmfifo_flags.sv
module dmfifo_flags
   import dmfifo_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  rd_mode_e                 mode,
   input  logic [$clog2(DEPTH):0]   tot,
   input  logic [$clog2(DEPTH)-1:0] empty_ofs,
   input  logic [$clog2(DEPTH)-1:0] full_ofs,
   output flag_set_t                flags
);
   localparam int CW   = $clog2(DEPTH) + 1;
   localparam int HALF = DEPTH / 2;

   logic          fall, is_full, is_empty;
   logic [CW-1:0] lvl, cap, af_mark;
   flag_set_t     nxt;

   always_comb begin
      fall     = (mode == MODE_FALL);
      cap      = fall ? CW'(DEPTH + 1) : CW'(DEPTH);
      // fall-through thresholds sit one word higher: normalise the level
      lvl      = (fall && tot != '0) ? tot - CW'(1) : tot;
      is_full  = (tot == cap);
      is_empty = (tot == '0);
      af_mark  = CW'(DEPTH) - CW'(full_ofs);

      nxt.rd_stat      = fall ? is_empty : ~is_empty;
      nxt.wr_stat      = fall ? is_full  : ~is_full;
      nxt.near_empty_n = (lvl > CW'(empty_ofs));
      nxt.half_n       = ~(lvl > CW'(HALF));
      nxt.near_full_n  = ~(lvl >= af_mark);
   end

   always_ff @(posedge clk) begin
      flags <= nxt;
   end

endmodule

// File: rtl/dualmode_fifo.sv
module dualmode_fifo
   import dmfifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mode_sel,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_en,
   output logic [DATA_W-1:0]        rd_data,
   input  logic [$clog2(DEPTH)-1:0] empty_ofs,
   input  logic [$clog2(DEPTH)-1:0] full_ofs,
   output logic                     rd_stat,
   output logic                     wr_stat,
   output logic                     half_n,
   output logic                     near_empty_n,
   output logic                     near_full_n
);
   localparam int CW = $clog2(DEPTH) + 1;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("dualmode_fifo: DATA_W must be at least 1");
      end
   endgenerate

   rd_mode_e          mode_q, mode_eff;
   logic              push, pop;
   logic [DATA_W-1:0] head_word;
   logic [CW-1:0]     tot_nxt, tot_eff;
   flag_set_t         flags;

   // mode latches only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= rd_mode_e'(mode_sel);
   end

   assign mode_eff = rst_n ? mode_q  : rd_mode_e'(mode_sel);
   assign tot_eff  = rst_n ? tot_nxt : '0;

   dmfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .wr_data   (wr_data),
      .head_word (head_word)
   );

   dmfifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_q),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .wr_data   (wr_data),
      .head_word (head_word),
      .push      (push),
      .pop       (pop),
      .rd_data   (rd_data),
      .tot_nxt   (tot_nxt)
   );

   dmfifo_flags #(.DEPTH(DEPTH)) u_flags (
      .clk       (clk),
      .mode      (mode_eff),
      .tot       (tot_eff),
      .empty_ofs (empty_ofs),
      .full_ofs  (full_ofs),
      .flags     (flags)
   );

   assign rd_stat      = flags.rd_stat;
   assign wr_stat      = flags.wr_stat;
   assign half_n       = flags.half_n;
   assign near_empty_n = flags.near_empty_n;
   assign near_full_n  = flags.near_full_n;

endmodule

// File: rtl/dualmode_fifo_checks.sv
module dualmode_fifo_checks
   import dmfifo_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input rd_mode_e          mode_q,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_stat,
   input logic              wr_stat,
   input logic              half_n,
   input logic              near_empty_n,
   input logic              near_full_n
);
   logic fall, full_now, empty_now;
   assign fall      = (mode_q == MODE_FALL);
   assign full_now  = fall ? wr_stat : ~wr_stat;
   assign empty_now = fall ? rd_stat : ~rd_stat;

   p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(mode_q));

   p_fall_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !rd_stat && !rd_en) |=> (!rd_stat && $stable(rd_data)));

   p_empty_low_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      empty_now |-> (!near_empty_n && half_n));

   p_full_near_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      full_now |-> !near_full_n);

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (full_now && wr_en && !rd_en) |=> full_now);

   p_empty_read_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall && empty_now && rd_en && !wr_en) |=> (!rd_stat && $stable(rd_data)));

   p_read_clears_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (full_now && rd_en) |=> !full_now);

endmodule

bind dualmode_fifo dualmode_fifo_checks #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_q       (mode_q),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .rd_data      (rd_data),
   .rd_stat      (rd_stat),
   .wr_stat      (wr_stat),
   .half_n       (half_n),
   .near_empty_n (near_empty_n),
   .near_full_n  (near_full_n)
);

// File: tb/dualmode_fifo_test.sv
`timescale 1ns/1ps
module dualmode_fifo_test;
   localparam int DW = 8;
   localparam int D  = 16;
   localparam int OW = $clog2(D);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_sel = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [OW-1:0] empty_ofs = '0;
   logic [OW-1:0] full_ofs = '0;
   logic          rd_stat, wr_stat, half_n, near_empty_n, near_full_n;

   always #4 clk = ~clk;

   dualmode_fifo #(.DATA_W(DW), .DEPTH(D)) uut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .empty_ofs(empty_ofs), .full_ofs(full_ofs),
      .rd_stat(rd_stat), .wr_stat(wr_stat), .half_n(half_n),
      .near_empty_n(near_empty_n), .near_full_n(near_full_n)
   );

   int n_run = 0;
   int n_fail = 0;
   logic [DW-1:0] q [0:255];
   logic [7:0]    head, tail;
   int            cnt, nofs, mofs;
   bit            fall;
   logic [DW-1:0] exp_rd;

   task automatic chk(string scen, string req, string what,
                      logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s %s: actual=%0h expected=%0h", scen, req, what, act, exp);
      end
   endtask

   task automatic check_all(string scen);
      int cap = fall ? D + 1 : D;
      chk(scen, fall ? "R3" : "R2", "rd_stat", rd_stat, fall ? (cnt == 0) : (cnt != 0));
      chk(scen, fall ? "R3" : "R2", "wr_stat", wr_stat, fall ? (cnt == cap) : (cnt != cap));
      chk(scen, fall ? "R6" : "R5", "near_empty_n", near_empty_n,
          fall ? (cnt >= nofs + 2) : (cnt >= nofs + 1));
      chk(scen, "R7", "half_n", half_n,
          !(fall ? (cnt >= D / 2 + 2) : (cnt >= D / 2 + 1)));
      chk(scen, "R8", "near_full_n", near_full_n,
          !(fall ? (cnt >= D + 1 - mofs) : (cnt >= D - mofs)));
      if (!fall) chk(scen, "R12", "rd_data", rd_data, exp_rd);
      else if (cnt > 0) chk(scen, "R4", "head word", rd_data, q[head]);
   endtask

   // request applied at a falling edge, result sampled at the next falling edge
   task automatic step(bit w, bit r, logic [DW-1:0] d, string scen);
      int  cap = fall ? D + 1 : D;
      bit  rd_ok, wr_ok;
      wr_en = w; rd_en = r; wr_data = d;
      rd_ok = r && (cnt > 0);
      wr_ok = w && (cnt < cap);
      @(posedge clk);
      if (rd_ok) begin
         if (!fall) exp_rd = q[head];
         head = head + 8'd1;
         cnt--;
      end
      if (wr_ok) begin
         q[tail] = d;
         tail = tail + 8'd1;
         cnt++;
      end
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check_all(scen);
   endtask

   task automatic do_reset(bit mode, int n, int m);
      mode_sel = mode; empty_ofs = OW'(n); full_ofs = OW'(m);
      nofs = n; mofs = m; rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      fall = mode; cnt = 0; head = '0; tail = '0; exp_rd = '0;
      chk("reset", "R1", "rd_stat", rd_stat, mode);
      chk("reset", "R1", "wr_stat", wr_stat, !mode);
      check_all("reset R1");
   endtask

   // R1: mode input toggled after reset must not switch the mode
   task automatic t_mode_latch(bit mode);
      do_reset(mode, 3, 2);
      mode_sel = !mode;
      step(1'b1, 1'b0, 8'h5A, "latch R1");
      chk("latch", "R1", "rd_stat after write", rd_stat, !mode);
      step(1'b0, 1'b1, 8'h00, "latch R1");
      mode_sel = mode;
   endtask

   // R2 R3 R5-R8 R9 R10 R12: fill past capacity, then drain past empty
   task automatic t_fill_drain(bit mode, int n, int m, int base);
      do_reset(mode, n, m);
      for (int i = 0; i < D + 3; i++) step(1'b1, 1'b0, DW'(base + i * 3), "fill R9");
      step(1'b0, 1'b1, 8'h00, "first read R10");
      step(1'b1, 1'b0, 8'hC3, "refill");
      for (int i = 0; i < D + 3; i++) step(1'b0, 1'b1, 8'h00, "drain R9");
   endtask

   // R11: simultaneous read and write at the full and empty boundaries
   task automatic t_boundary(bit mode);
      do_reset(mode, 2, 3);
      for (int i = 0; i < D + 1; i++) step(1'b1, 1'b0, DW'(8'h40 + i), "to full");
      step(1'b1, 1'b1, 8'hEE, "full rd+wr R11");
      chk("boundary", "R11", "count after full rd+wr", cnt, (mode ? D + 1 : D) - 1);
      for (int i = 0; i < D + 1; i++) step(1'b0, 1'b1, 8'h00, "to empty");
      step(1'b1, 1'b1, 8'h77, "empty rd+wr R11");
      step(1'b0, 1'b1, 8'h00, "read back R11");
   endtask

   // R4: fall-through head word appears without read enable and holds
   task automatic t_fall_head;
      do_reset(1'b1, 3, 2);
      step(1'b1, 1'b0, 8'hA5, "first word R4");
      chk("head", "R4", "rd_data", rd_data, 8'hA5);
      step(1'b1, 1'b0, 8'hB6, "second word R4");
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'h00, "idle hold R4");
      chk("head", "R4", "rd_data held", rd_data, 8'hA5);
      step(1'b0, 1'b1, 8'h00, "advance R4");
      chk("head", "R4", "rd_data next", rd_data, 8'hB6);
   endtask

   // R12: mixed stream of reads and writes
   task automatic t_mixed(bit mode);
      do_reset(mode, 4, 4);
      for (int i = 0; i < 160; i++)
         step((i % 3) != 2, (i % 4) == 1 || (i > 100 && (i % 2) == 0),
              DW'(i * 7 + 1), "mixed R12");
   endtask

   initial begin
      @(negedge clk);
      t_mode_latch(1'b0);
      t_mode_latch(1'b1);
      t_fill_drain(1'b0, 3, 2, 16);
      t_fill_drain(1'b1, 3, 2, 100);
      t_fill_drain(1'b0, 0, 7, 3);
      t_fill_drain(1'b1, 7, 0, 200);
      t_boundary(1'b0);
      t_boundary(1'b1);
      t_fall_head;
      t_mixed(1'b0);
      t_mixed(1'b1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog all: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule